// File: doc/BRIEF.md
# SDRAM Bank Command Legality Tracker

This block sits on the command pins of a single-data-rate SDRAM interface and follows what one bank is doing. On each clock it turns chip select, row strobe, column strobe and write enable into a command. It then moves a model of the bank through its states: idle, opening a row, row open, reading, writing, closing the row, and reading or writing with automatic close. Commands that the bank's present state does not accept are reported on a one-cycle error flag.

The two transient intervals are counted in clock cycles. Opening a row lasts `T_RCD` cycles and closing a row lasts `T_RP` cycles. A burst issued with automatic close keeps the bank busy until a burst-complete pulse arrives, and then for a further `T_RP` cycles. The block is meant for a controller's self-check logic or for a protocol monitor next to a memory model. Each bank that needs watching gets its own instance.

Top module: `sdram_bank_guard`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n}. cs_n high is inhibit. With cs_n low: 0111 no-op, 0011 open row, 0101 read, 0100 write, 0110 burst stop, 0010 close row, 0001 refresh, 0000 mode load.
- R2: The tracker advances, its cycle counter counts and the error flag can rise only on an edge where `cke` is high and was also high at the previous edge. On any other edge, state and counter hold and the flag is low.
- R3: While `rst_n` is low, `state_o` is 0 (idle) and `illegal_o` is 0. The state codes are: 0 idle, 1 opening, 2 row open, 3 reading, 4 writing, 5 closing, 6 reading with auto close, 7 writing with auto close.
- R4: In idle, open row, refresh, mode load, close row, no-op and inhibit are accepted. Open row moves to opening. Every other accepted command leaves the bank idle. Read, write and burst stop are illegal.
- R5: Opening lasts exactly `T_RCD` cycles and then becomes row open. Only no-op and inhibit are legal while opening.
- R6: In row open, read goes to reading and write goes to writing; with `ap_bit` high they go to the auto-close variants instead. Close row goes to closing. Open row, refresh, mode load and burst stop are illegal.
- R7: While reading or writing, a read or write starts a new burst of that kind, chosen by `ap_bit` as in R6. Close row cuts the burst short and goes to closing. Burst stop, or `burst_done` with no other command, returns to row open. Open row, refresh and mode load are illegal.
- R8: Closing lasts exactly `T_RP` cycles and then becomes idle. Only no-op and inhibit are legal while closing.
- R9: An auto-close state holds until `burst_done` is seen. It becomes idle `T_RP` cycles after that edge. Only no-op and inhibit are legal throughout.
- R10: An illegal command raises `illegal_o` in the cycle after the edge that sampled it. It is then handled as a no-op: it causes no state change, and timed exits and `burst_done` still take effect. `burst_done` has no effect in idle, opening, row open or closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable observed on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| burst_done | input | 1 | Pulse marking the end of the current burst |
| ap_bit | input | 1 | Auto-close select sampled with read or write |
| state_o | output | 3 | Current bank state code |
| illegal_o | output | 1 | One-cycle flag for a rejected command |

## Verification
The bench measures the length of the opening and closing windows edge by edge. A counter that is off by one would show row open or idle one cycle early or late. It places an illegal read inside the opening window to confirm that the window still ends on time; a design that restarted or stalled its counter on a rejected command would miss that cycle. It sends `burst_done` to an idle bank and a read to an auto-close bank, where a careless design would change state. It holds `cke` low in the middle of opening, and also on the first edge after `cke` returns high; counting on either of those edges would shorten the window.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    typedef enum logic [3:0] {
        CMD_INH,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE,
        CMD_REF,
        CMD_LMR
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_ROW   = 3'd2,
        ST_RD    = 3'd3,
        ST_WR    = 3'd4,
        ST_CLOSE = 3'd5,
        ST_RD_AP = 3'd6,
        ST_WR_AP = 3'd7
    } bank_st_e;

    typedef struct packed {
        bank_st_e st;
        logic     ill;
        logic     cke_prev;
        logic     drain;
    } ctl_s;

endpackage

// File: rtl/sbg_cmd_decode.sv
module sbg_cmd_decode
    import sbg_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_INH;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_LMR;
            endcase
        end
    end
endmodule

// File: rtl/sbg_legal.sv
module sbg_legal
    import sbg_pkg::*;
(
    input  bank_st_e st,
    input  cmd_e     cmd,
    output logic     ok
);
    always_comb begin
        if (cmd == CMD_INH || cmd == CMD_NOP) begin
            ok = 1'b1;
        end else begin
            case (st)
                ST_IDLE: ok = (cmd == CMD_ACT) || (cmd == CMD_REF) ||
                              (cmd == CMD_LMR) || (cmd == CMD_PRE);
                ST_ROW:  ok = (cmd == CMD_RD) || (cmd == CMD_WR) ||
                              (cmd == CMD_PRE);
                ST_RD,
                ST_WR:   ok = (cmd == CMD_RD) || (cmd == CMD_WR) ||
                              (cmd == CMD_PRE) || (cmd == CMD_BST);
                default: ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sbg_timer.sv
module sbg_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (en && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
    import sbg_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       burst_done,
    input  logic       ap_bit,
    output logic [2:0] state_o,
    output logic       illegal_o
);
    localparam int MAX_DLY = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int CW      = $clog2(MAX_DLY + 1);
    localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);

    ctl_s          ctl_d, ctl_q;
    cmd_e          cmd;
    cmd_e          eff;
    logic          ok;
    logic          en;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_exp;

    sbg_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    sbg_legal u_legal (
        .st (ctl_q.st),
        .cmd(cmd),
        .ok (ok)
    );

    sbg_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load    (t_load),
        .load_val(t_val),
        .expired (t_exp)
    );

    assign en = ctl_q.cke_prev && cke;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.cke_prev = cke;
        ctl_d.ill      = en && !ok;
        eff            = ok ? cmd : CMD_NOP;
        t_load         = 1'b0;
        t_val          = RCD_LD;
        if (en) begin
            case (ctl_q.st)
                ST_IDLE: begin
                    if (eff == CMD_ACT) begin
                        ctl_d.st = ST_OPEN;
                        t_load   = 1'b1;
                        t_val    = RCD_LD;
                    end
                end
                ST_OPEN: begin
                    if (t_exp) ctl_d.st = ST_ROW;
                end
                ST_ROW, ST_RD, ST_WR: begin
                    if (eff == CMD_RD) begin
                        ctl_d.st = ap_bit ? ST_RD_AP : ST_RD;
                    end else if (eff == CMD_WR) begin
                        ctl_d.st = ap_bit ? ST_WR_AP : ST_WR;
                    end else if (eff == CMD_PRE) begin
                        ctl_d.st = ST_CLOSE;
                        t_load   = 1'b1;
                        t_val    = RP_LD;
                    end else if (ctl_q.st != ST_ROW &&
                                 (eff == CMD_BST || burst_done)) begin
                        ctl_d.st = ST_ROW;
                    end
                end
                ST_CLOSE: begin
                    if (t_exp) ctl_d.st = ST_IDLE;
                end
                default: begin
                    if (ctl_q.drain) begin
                        if (t_exp) begin
                            ctl_d.st    = ST_IDLE;
                            ctl_d.drain = 1'b0;
                        end
                    end else if (burst_done) begin
                        ctl_d.drain = 1'b1;
                        t_load      = 1'b1;
                        t_val       = RP_LD;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, ill: 1'b0, cke_prev: 1'b0, drain: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o   = ctl_q.st;
    assign illegal_o = ctl_q.ill;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker
    import sbg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic [2:0] state_o,
    input logic       illegal_o
);
    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (!illegal_o && $stable(state_o)));

    assert_open_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OPEN) |=> (state_o == ST_OPEN || state_o == ST_ROW));

    assert_open_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OPEN && $past(state_o) != ST_OPEN) |->
            ($past(state_o) == ST_IDLE));

    assert_row_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ROW && $past(state_o) != ST_ROW) |->
            ($past(state_o) == ST_OPEN || $past(state_o) == ST_RD ||
             $past(state_o) == ST_WR));

    assert_close_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_CLOSE) |=> (state_o == ST_CLOSE || state_o == ST_IDLE));

    assert_ap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RD_AP || state_o == ST_WR_AP) |=>
            (state_o == $past(state_o) || state_o == ST_IDLE));

    assert_idle_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && $past(state_o) == ST_IDLE) |-> (state_o == ST_IDLE));
endmodule

bind sdram_bank_guard sbg_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .state_o  (state_o),
    .illegal_o(illegal_o)
);

// File: tb/sdram_bank_guard_tb_top.sv
module sdram_bank_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       burst_done = 1'b0;
    logic       ap_bit = 1'b0;
    logic [2:0] state_o;
    logic       illegal_o;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    sdram_bank_guard #(.T_RCD(3), .T_RP(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .burst_done(burst_done), .ap_bit(ap_bit),
        .state_o(state_o), .illegal_o(illegal_o)
    );

    localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101,
                           WR = 4'b0100, BST = 4'b0110, PRE = 4'b0010,
                           REF = 4'b0001, LMR = 4'b0000, INH = 4'b1111;

    // {cmd[3:0], ap, burst_done, expected state[2:0], expected flag}
    localparam int NV = 50;
    localparam logic [9:0] VEC [NV] = '{
        {NOP, 1'b0, 1'b0, 3'd0, 1'b0},  // gated first edge after reset
        {RD,  1'b0, 1'b0, 3'd0, 1'b1},  // R4 read illegal in idle
        {REF, 1'b0, 1'b0, 3'd0, 1'b0},  // R4
        {LMR, 1'b0, 1'b0, 3'd0, 1'b0},  // R4
        {PRE, 1'b0, 1'b0, 3'd0, 1'b0},  // R4
        {ACT, 1'b0, 1'b0, 3'd1, 1'b0},  // R4 -> opening
        {RD,  1'b0, 1'b0, 3'd1, 1'b1},  // R5 R10 illegal while opening
        {NOP, 1'b0, 1'b0, 3'd1, 1'b0},  // R5
        {NOP, 1'b0, 1'b0, 3'd2, 1'b0},  // R5 row open after 3 cycles
        {BST, 1'b0, 1'b0, 3'd2, 1'b1},  // R6 stop illegal in row open
        {RD,  1'b0, 1'b0, 3'd3, 1'b0},  // R6
        {NOP, 1'b0, 1'b0, 3'd3, 1'b0},  // R7
        {RD,  1'b0, 1'b0, 3'd3, 1'b0},  // R7 restart
        {WR,  1'b0, 1'b0, 3'd4, 1'b0},  // R7 read -> write
        {RD,  1'b0, 1'b0, 3'd3, 1'b0},  // R7 write -> read
        {BST, 1'b0, 1'b0, 3'd2, 1'b0},  // R7 stop
        {WR,  1'b0, 1'b0, 3'd4, 1'b0},  // R6
        {NOP, 1'b0, 1'b1, 3'd2, 1'b0},  // R7 burst_done
        {RD,  1'b0, 1'b0, 3'd3, 1'b0},  // R6
        {ACT, 1'b0, 1'b0, 3'd3, 1'b1},  // R7 R10 open illegal in read
        {PRE, 1'b0, 1'b0, 3'd5, 1'b0},  // R7 truncate
        {NOP, 1'b0, 1'b0, 3'd5, 1'b0},  // R8
        {NOP, 1'b0, 1'b0, 3'd0, 1'b0},  // R8 idle after 2 cycles
        {NOP, 1'b0, 1'b1, 3'd0, 1'b0},  // R10 burst_done ignored in idle
        {ACT, 1'b0, 1'b0, 3'd1, 1'b0},
        {INH, 1'b0, 1'b0, 3'd1, 1'b0},  // R1 R5 inhibit legal
        {NOP, 1'b0, 1'b0, 3'd1, 1'b0},
        {NOP, 1'b0, 1'b0, 3'd2, 1'b0},
        {WR,  1'b1, 1'b0, 3'd7, 1'b0},  // R6 write auto close
        {NOP, 1'b0, 1'b0, 3'd7, 1'b0},  // R9 holds
        {RD,  1'b0, 1'b0, 3'd7, 1'b1},  // R9 R10 read illegal
        {NOP, 1'b0, 1'b1, 3'd7, 1'b0},  // R9 burst done
        {NOP, 1'b0, 1'b0, 3'd7, 1'b0},  // R9
        {NOP, 1'b0, 1'b0, 3'd0, 1'b0},  // R9 idle T_RP after done
        {ACT, 1'b0, 1'b0, 3'd1, 1'b0},
        {NOP, 1'b0, 1'b0, 3'd1, 1'b0},
        {NOP, 1'b0, 1'b0, 3'd1, 1'b0},
        {NOP, 1'b0, 1'b0, 3'd2, 1'b0},
        {RD,  1'b1, 1'b0, 3'd6, 1'b0},  // R6 read auto close
        {NOP, 1'b0, 1'b1, 3'd6, 1'b0},  // R9
        {BST, 1'b0, 1'b0, 3'd6, 1'b1},  // R9 R10 timing continues
        {NOP, 1'b0, 1'b0, 3'd0, 1'b0},  // R9
        {ACT, 1'b0, 1'b0, 3'd1, 1'b0},
        {NOP, 1'b0, 1'b0, 3'd1, 1'b0},
        {NOP, 1'b0, 1'b0, 3'd1, 1'b0},
        {NOP, 1'b0, 1'b0, 3'd2, 1'b0},
        {WR,  1'b0, 1'b0, 3'd4, 1'b0},
        {PRE, 1'b0, 1'b0, 3'd5, 1'b0},  // R7 truncate write
        {NOP, 1'b0, 1'b0, 3'd5, 1'b0},  // R8
        {NOP, 1'b0, 1'b0, 3'd0, 1'b0}   // R8
    };

    task automatic check(input string req, input logic [2:0] exp_st, input logic exp_ill);
        n_chk++;
        if (state_o !== exp_st || illegal_o !== exp_ill) begin
            n_fail++;
            $display("FAIL %s: state=%0d flag=%0b expected state=%0d flag=%0b",
                     req, state_o, illegal_o, exp_st, exp_ill);
        end
    endtask

    task automatic step(input logic [3:0] c, input logic a, input logic b, input logic k);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        ap_bit     = a;
        burst_done = b;
        cke        = k;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3 reset", 3'd0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][9:6], VEC[i][5], VEC[i][4], 1'b1);
            check($sformatf("R1 vector %0d", i), VEC[i][3:1], VEC[i][0]);
        end

        // R3: reset mid-operation
        step(ACT, 1'b0, 1'b0, 1'b1);
        check("R5 open before reset", 3'd1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R3 async reset", 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: clock-enable gating
        step(NOP, 1'b0, 1'b0, 1'b1);
        step(ACT, 1'b0, 1'b0, 1'b0);
        check("R2 cke low ignores open", 3'd0, 1'b0);
        step(RD, 1'b0, 1'b0, 1'b0);
        check("R2 cke low no flag", 3'd0, 1'b0);
        step(RD, 1'b0, 1'b0, 1'b1);
        check("R2 first edge after cke rise", 3'd0, 1'b0);
        step(RD, 1'b0, 1'b0, 1'b1);
        check("R4 read flagged in idle", 3'd0, 1'b1);
        step(ACT, 1'b0, 1'b0, 1'b1);
        check("R5 opening", 3'd1, 1'b0);
        step(NOP, 1'b0, 1'b0, 1'b0);
        step(NOP, 1'b0, 1'b0, 1'b0);
        step(NOP, 1'b0, 1'b0, 1'b1);
        check("R2 count frozen", 3'd1, 1'b0);
        step(NOP, 1'b0, 1'b0, 1'b1);
        check("R2 R5 count 1", 3'd1, 1'b0);
        step(NOP, 1'b0, 1'b0, 1'b1);
        check("R2 R5 count 2", 3'd1, 1'b0);
        step(NOP, 1'b0, 1'b0, 1'b1);
        check("R5 row open", 3'd2, 1'b0);
        step(REF, 1'b0, 1'b1, 1'b1);
        check("R6 refresh illegal, done ignored", 3'd2, 1'b1);
        step(NOP, 1'b0, 1'b0, 1'b1);
        check("R10 flag single cycle", 3'd2, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule